// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block sits beside an SPI slave and lets the bus master pause a transaction without deselecting the slave. It samples the chip-select, serial-clock and pause pins on the system clock, through a synchronizer of configurable depth. From those samples it keeps a registered `hold_active` flag. The pause starts or ends only at a moment when the serial clock is sampled low. A pause request that arrives while the clock is high waits for the next low sample of the clock.

While paused, the block suppresses the qualified clock-edge strobes that drive the slave's shifters, forces the data-out enable low so MISO floats, and freezes its bit-position counter. Shifting then resumes from the same bit once the pause ends. Releasing chip select during a pause ends the pause and raises a one-cycle abort pulse, which the slave uses to drop the transaction.

Top module: `spi_hold_ctrl`

## Requirements
- R1: During and right after reset, `hold_active`, `sck_rise_en`, `sck_fall_en`, `abort_pulse` and `bit_idx` are all 0.
- R2: Each pin passes through SYNC_STAGES synchronizer flops and then one output register. Every registered output therefore reflects pin values sampled SYNC_STAGES+1 clock edges earlier.
- R3: With chip select low (`cs_n`=0) and the clock sampled low, a low `hold_n` sets `hold_active` to 1.
- R4: While the clock is sampled high, `hold_active` does not change, whatever `hold_n` does. A pause request or release made with the clock high takes effect at the next low sample of the clock.
- R5: With chip select low and the clock sampled low, a high `hold_n` clears `hold_active`.
- R6: When chip select is sampled high, `hold_active` is 0 on the next edge, and a low `hold_n` cannot start a pause.
- R7: If chip select is sampled high while `hold_active` is 1, `abort_pulse` is 1 for exactly one clock.
- R8: `miso_oe` equals `slv_oe` AND NOT `hold_active`.
- R9: `sck_rise_en` pulses for one clock on a sampled 0-to-1 clock change when chip select is low and no pause is active. `sck_fall_en` pulses on a sampled 1-to-0 change when chip select is low and no pause is in force after that sample.
- R10: `bit_idx` counts `sck_rise_en` pulses modulo WORD_BITS (8 by default, so after 7 comes 0). It keeps its value during a pause and is 0 whenever chip select is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| hold_n | input | 1 | Pause request pin, active low |
| slv_oe | input | 1 | Data-out enable requested by the slave |
| hold_active | output | 1 | Pause in force |
| sck_rise_en | output | 1 | Qualified rising-edge strobe for the slave |
| sck_fall_en | output | 1 | Qualified falling-edge strobe for the slave |
| abort_pulse | output | 1 | One-cycle pulse on deselect during a pause |
| miso_oe | output | 1 | Gated MISO output enable |
| bit_idx | output | $clog2(WORD_BITS) | Bit position within the current word |

## Verification
The embedded assertions check on every cycle that the pause flag never moves while the clock is sampled high, that a deselect clears it, and that the abort pulse lasts a single cycle. They also check that MISO is disabled and rising strobes and the bit counter are held for as long as a pause lasts. The cycle-accurate latency through the synchronizer, deferred entry and exit, resumption from the kept bit position, and counter wrap are shown only by the bench's scenarios, which compare each output against a behavioural model on every clock.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Pause state after one sample: deselect clears, low clock loads request.
  function automatic logic hold_next(logic cs_n, logic sck, logic hold_n, logic cur);
    if (cs_n)      return 1'b0;
    else if (!sck) return !hold_n;
    else           return cur;
  endfunction

  // Bit position advance with wrap at the word length.
  function automatic int unsigned idx_step(int unsigned idx, int unsigned word_bits);
    if (idx + 1 >= word_bits) return 0;
    else                      return idx + 1;
  endfunction

endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hsc_core.sv
module hsc_core
  import spi_hold_pkg::*;
#(
  parameter int WORD_BITS = 8,
  localparam int IDXW = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_cs_n,
  input  logic            s_sck,
  input  logic            s_hold_n,
  input  logic            slv_oe,
  output logic            hold_active,
  output logic            sck_rise_en,
  output logic            sck_fall_en,
  output logic            abort_pulse,
  output logic            miso_oe,
  output logic [IDXW-1:0] bit_idx
);
  logic sck_prev;
  logic raw_rise, raw_fall;
  logic hold_d;
  logic rise_ok, fall_ok, abort_ok;
  logic [IDXW-1:0] idx_d;

  // Named internal events
  assign raw_rise = s_sck & ~sck_prev;
  assign raw_fall = ~s_sck & sck_prev;
  assign hold_d   = hold_next(s_cs_n, s_sck, s_hold_n, hold_active);
  assign rise_ok  = raw_rise & ~s_cs_n & ~hold_active;
  assign fall_ok  = raw_fall & ~s_cs_n & ~hold_d;
  assign abort_ok = hold_active & s_cs_n;

  always_comb begin
    if (s_cs_n)       idx_d = '0;
    else if (rise_ok) idx_d = IDXW'(idx_step(int'(unsigned'(bit_idx)), WORD_BITS));
    else              idx_d = bit_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev    <= 1'b0;
      hold_active <= 1'b0;
      sck_rise_en <= 1'b0;
      sck_fall_en <= 1'b0;
      abort_pulse <= 1'b0;
      bit_idx     <= '0;
    end else begin
      sck_prev    <= s_sck;
      hold_active <= hold_d;
      sck_rise_en <= rise_ok;
      sck_fall_en <= fall_ok;
      abort_pulse <= abort_ok;
      bit_idx     <= idx_d;
    end
  end

  assign miso_oe = slv_oe & ~hold_active;

  AST_CS_CLEARS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs_n |=> !hold_active); // R6
  AST_HOLD_FROZEN_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sck && !s_cs_n) |=> $stable(hold_active)); // R4
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse); // R7
  AST_ABORT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !hold_active); // R7
  AST_MISO_HIZ_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !miso_oe); // R8
  AST_NO_RISE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> !sck_rise_en); // R9
  AST_IDX_KEPT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !s_cs_n) |=> $stable(bit_idx)); // R10
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = 8,
  localparam int IDXW = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            hold_n,
  input  logic            slv_oe,
  output logic            hold_active,
  output logic            sck_rise_en,
  output logic            sck_fall_en,
  output logic            abort_pulse,
  output logic            miso_oe,
  output logic [IDXW-1:0] bit_idx
);
  logic s_cs_n, s_sck, s_hold_n;

  hsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(s_cs_n));
  hsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(s_sck));
  hsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hold (
    .clk(clk), .rst_n(rst_n), .d(hold_n), .q(s_hold_n));

  hsc_core #(.WORD_BITS(WORD_BITS)) u_core (
    .clk(clk), .rst_n(rst_n),
    .s_cs_n(s_cs_n), .s_sck(s_sck), .s_hold_n(s_hold_n), .slv_oe(slv_oe),
    .hold_active(hold_active), .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
    .abort_pulse(abort_pulse), .miso_oe(miso_oe), .bit_idx(bit_idx));
endmodule

// File: tb/spi_hold_ctrl_tb_top.sv
module spi_hold_ctrl_tb_top;
  localparam int NS = 2;
  localparam int WB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, slv_oe = 1'b0;
  logic hold_active, sck_rise_en, sck_fall_en, abort_pulse, miso_oe;
  logic [2:0] bit_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit abort_win = 0;
  int abort_cnt = 0;

  always #2.5 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(NS), .WORD_BITS(WB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n), .slv_oe(slv_oe),
    .hold_active(hold_active), .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
    .abort_pulse(abort_pulse), .miso_oe(miso_oe), .bit_idx(bit_idx));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: queued pin samples, delayed NS edges
  int q_cs[$], q_sck[$], q_hold[$];
  int m_prev = 0, m_hold = 0, m_rise = 0, m_fall = 0, m_abort = 0, m_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_cs = {}; q_sck = {}; q_hold = {};
      for (int i = 0; i < NS; i++) begin q_cs.push_back(1); q_sck.push_back(0); q_hold.push_back(1); end
      m_prev = 0; m_hold = 0; m_rise = 0; m_fall = 0; m_abort = 0; m_idx = 0;
    end else begin
      int c, s, h, after;
      bit up, dn;
      c = q_cs.pop_front(); s = q_sck.pop_front(); h = q_hold.pop_front();
      q_cs.push_back(cs_n); q_sck.push_back(sck); q_hold.push_back(hold_n);
      up = (s == 1) && (m_prev == 0);
      dn = (s == 0) && (m_prev == 1);
      if (c == 1) after = 0;
      else if (s == 0) after = (h == 0);
      else after = m_hold;
      m_rise  = (up && c == 0 && m_hold == 0);
      m_fall  = (dn && c == 0 && after == 0);
      m_abort = (m_hold == 1 && c == 1);
      if (c == 1) m_idx = 0;
      else if (m_rise) m_idx = (m_idx + 1) % WB;
      m_hold = after;
      m_prev = s;
    end
    #2;
    if (abort_win && abort_pulse) abort_cnt++;
    if (rst_n) begin
      chk("R2 R3 R4 R5 R6 hold_active", hold_active, m_hold);
      chk("R9 sck_rise_en", sck_rise_en, m_rise);
      chk("R9 sck_fall_en", sck_fall_en, m_fall);
      chk("R7 abort_pulse", abort_pulse, m_abort);
      chk("R8 miso_oe", miso_oe, slv_oe && !m_hold);
      chk("R10 bit_idx", bit_idx, m_idx);
    end
  end

  task automatic drv(logic c, logic s, logic h, int n);
    cs_n = c; sck = s; hold_n = h;
    repeat (n) @(negedge clk);
  endtask

  task automatic clocks(int n);
    for (int i = 0; i < n; i++) begin
      drv(1'b0, 1'b1, 1'b1, 5);
      drv(1'b0, 1'b0, 1'b1, 5);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hold_active in reset", hold_active, 0);
    chk("R1 bit_idx in reset", bit_idx, 0);
    chk("R1 abort_pulse in reset", abort_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", sck_rise_en | sck_fall_en, 0);
    slv_oe = 1'b1;
    drv(1'b0, 1'b0, 1'b1, 5);
    clocks(3);
    chk("R10 three edges", bit_idx, 3);
    // latency: pause requested with clock low
    drv(1'b0, 1'b0, 1'b0, 1);
    chk("R2 no change after 1 edge", hold_active, 0);
    @(negedge clk);
    chk("R2 no change after 2 edges", hold_active, 0);
    @(negedge clk);
    chk("R2 R3 hold after 3 edges", hold_active, 1);
    chk("R8 miso floats", miso_oe, 0);
    drv(1'b0, 1'b1, 1'b0, 5);
    drv(1'b0, 1'b0, 1'b0, 5);
    drv(1'b0, 1'b1, 1'b0, 5);
    drv(1'b0, 1'b0, 1'b0, 5);
    chk("R10 index kept in hold", bit_idx, 3);
    chk("R3 still paused", hold_active, 1);
    drv(1'b0, 1'b0, 1'b1, 5);
    chk("R5 resume", hold_active, 0);
    chk("R8 miso driven", miso_oe, 1);
    clocks(2);
    chk("R10 resumes from kept position", bit_idx, 5);
    // request while clock high: deferred
    drv(1'b0, 1'b1, 1'b0, 6);
    chk("R4 entry deferred", hold_active, 0);
    chk("R10 edge before pause counted", bit_idx, 6);
    drv(1'b0, 1'b0, 1'b0, 6);
    chk("R4 entry at clock low", hold_active, 1);
    drv(1'b0, 1'b1, 1'b1, 6);
    chk("R4 exit deferred", hold_active, 1);
    chk("R9 R10 no count in pause", bit_idx, 6);
    drv(1'b0, 1'b0, 1'b1, 6);
    chk("R4 R5 exit at clock low", hold_active, 0);
    clocks(3);
    chk("R10 wraps", bit_idx, 1);
    // deselect during pause
    drv(1'b0, 1'b0, 1'b0, 6);
    chk("R3 paused before abort", hold_active, 1);
    abort_win = 1;
    drv(1'b1, 1'b0, 1'b0, 8);
    abort_win = 0;
    chk("R7 single abort pulse", abort_cnt, 1);
    chk("R6 deselect clears hold", hold_active, 0);
    chk("R10 deselect zeroes index", bit_idx, 0);
    drv(1'b1, 1'b0, 1'b0, 6);
    chk("R6 no pause while deselected", hold_active, 0);
    drv(1'b1, 1'b0, 1'b1, 4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule